// File: doc/BRIEF.md
# Configuration-capable JTAG test access port

The block is a serial test and configuration port built around a sixteen-state TAP controller clocked by TCK and steered by TMS. A five-bit instruction register picks which data register sits between TDI and TDO. Besides the usual bypass and identification registers, it offers a user-code register and two eight-bit registers: an address register and a read/write data register. Through these, an external tester can read and write words of an internal register file.

Six of the instruction codes have no data register. When one of them becomes the current instruction, the block issues a one-TCK command pulse on the internal side. These pulses ask the surrounding logic to reload the register file from flash, to save it to flash, or to switch the flash page and user-flash access windows. The block also holds the two window states as flags.

The controller and the instruction register are reset asynchronously by `rst_ni`, and also reach the reset state after five TCK cycles with TMS high. TDO and its enable change on the falling edge of TCK. All other state changes on the rising edge, except the instruction latch, the address and write-data update and the command pulses, which change on the falling edge.

Top module: `jtag_cfg_port`

## Requirements
- R1: While `rst_ni` is low, or after at least five rising TCK edges with TMS high, the controller is in Test-Logic-Reset. The current instruction becomes IDCODE (code 0x00), and `tdo_oe_o` is low.
- R2: State transitions follow the IEEE 1149.1 TAP graph. `tdo_oe_o` is high exactly during the TCK cycles, counted from falling edge to falling edge, in which the controller is in Shift-IR or Shift-DR.
- R3: Capture-IR loads 5'b00001 into the instruction shift stage. In Shift-IR the stage shifts one bit toward TDO on every rising TCK, TDI enters at bit 4, and TDO presents bit 0 from the falling edge.
- R4: The shifted code becomes the current instruction on the falling TCK edge in Update-IR. A path through Pause-IR and Exit2-IR keeps the shifted contents intact.
- R5: IDCODE (0x00) selects a 32-bit register. On the rising edge that leaves Capture-DR it loads {version[3:0], part[15:0], manufacturer[10:0], 1'b1}, and it shifts out LSB first.
- R6: USERCODE (0x03) selects a 32-bit register that captures the parameter `USER_CODE` and shifts it out LSB first.
- R7: BYPASS (0x1F), every unassigned code and every command code (0x07 to 0x0C) select a one-bit register that captures 0. TDI appears on TDO one TCK later.
- R8: LOAD ADDRESS (0x04) selects an 8-bit register that captures the current `rf_addr_o`. On the falling edge in Update-DR, the shifted word drives `rf_addr_o`. The address changes at no other time.
- R9: READ DATA (0x05) selects an 8-bit register that captures `rf_rdata_i` in Capture-DR and shifts it out LSB first.
- R10: WRITE DATA (0x06) raises `rf_we_o` for exactly one TCK, starting at the falling edge in Update-DR, with the shifted word on `rf_wdata_o`. `rf_we_o` stays low under every other instruction.
- R11: Each time a command code is latched in Update-IR, one bit of `cmd_o` is high for one TCK, starting at that falling edge. The bit mapping is: 0x07 to bit 0, 0x08 to bit 1, 0x09 to bit 2, 0x0A to bit 3, 0x0B to bit 4, 0x0C to bit 5. At most one bit is high at any time.
- R12: The flags work as follows:
  - 0x09 sets `flash_page_o`.
  - 0x0A clears both `flash_page_o` and `user_flash_o`.
  - 0x0C clears `user_flash_o`.
  - 0x0B sets `user_flash_o` and pulses bit 4 only if `flash_page_o` is already set. Otherwise it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe_o | output | 1 | Output enable for TDO |
| rf_addr_o | output | ADDR_W | Register-file address |
| rf_wdata_o | output | DATA_W | Register-file write word |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_rdata_i | input | DATA_W | Register-file read word at rf_addr_o |
| cmd_o | output | 6 | One-TCK command pulses |
| flash_page_o | output | 1 | Flash page access active |
| user_flash_o | output | 1 | User flash access active |

## Verification
A wrong controller state shows up first on `tdo_oe_o`: a stray transition moves the shift window by at least one TCK, which is visible at the next falling edge. A wrongly chosen instruction or a misplaced capture shows as a wrong TDO bit within one TCK of entering Shift-DR. A wrongly decoded update shows on `rf_addr_o`, `rf_we_o`, `cmd_o` or the flags at the falling edge of the update cycle itself. Comparing every output at every falling edge therefore catches each fault within the TCK cycle in which it becomes observable.

// File: rtl/jtag_cfg_pkg.sv
package jtag_cfg_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  localparam int unsigned IR_W = 5;

  localparam logic [IR_W-1:0] OP_IDCODE   = 5'h00;
  localparam logic [IR_W-1:0] OP_USERCODE = 5'h03;
  localparam logic [IR_W-1:0] OP_LD_ADDR  = 5'h04;
  localparam logic [IR_W-1:0] OP_RD_DATA  = 5'h05;
  localparam logic [IR_W-1:0] OP_WR_DATA  = 5'h06;
  localparam logic [IR_W-1:0] OP_REBOOT   = 5'h07;
  localparam logic [IR_W-1:0] OP_SAVE     = 5'h08;
  localparam logic [IR_W-1:0] OP_PAGE_ON  = 5'h09;
  localparam logic [IR_W-1:0] OP_PAGE_OFF = 5'h0A;
  localparam logic [IR_W-1:0] OP_USER_ON  = 5'h0B;
  localparam logic [IR_W-1:0] OP_USER_OFF = 5'h0C;
  localparam logic [IR_W-1:0] OP_BYPASS   = 5'h1F;

  localparam int unsigned CMD_W        = 6;
  localparam int unsigned CMD_REBOOT   = 0;
  localparam int unsigned CMD_SAVE     = 1;
  localparam int unsigned CMD_PAGE_ON  = 2;
  localparam int unsigned CMD_PAGE_OFF = 3;
  localparam int unsigned CMD_USER_ON  = 4;
  localparam int unsigned CMD_USER_OFF = 5;

  typedef enum logic [2:0] {
    DS_BYP, DS_ID, DS_USER, DS_ADDR, DS_DATA
  } dr_sel_e;

  function automatic dr_sel_e dr_select(logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:              return DS_ID;
      OP_USERCODE:            return DS_USER;
      OP_LD_ADDR:             return DS_ADDR;
      OP_RD_DATA, OP_WR_DATA: return DS_DATA;
      default:                return DS_BYP;
    endcase
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_cfg_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TS_RESET:  st_d = tms_i ? TS_RESET  : TS_IDLE;
      TS_IDLE:   st_d = tms_i ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: st_d = tms_i ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: st_d = tms_i ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  st_d = tms_i ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: st_d = tms_i ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: st_d = tms_i ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: st_d = tms_i ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: st_d = tms_i ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: st_d = tms_i ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: st_d = tms_i ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  st_d = tms_i ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: st_d = tms_i ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: st_d = tms_i ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: st_d = tms_i ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: st_d = tms_i ? TS_SEL_DR : TS_IDLE;
      default:   st_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= TS_RESET;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/jtag_ir.sv
module jtag_ir
  import jtag_cfg_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic            ir_tdo_o,
  output logic [IR_W-1:0] ir_shift_o,
  output logic [IR_W-1:0] instr_o
);

  localparam logic [IR_W-1:0] CAPTURE_PAT = IR_W'(1);

  logic [IR_W-1:0] sh_q, instr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= CAPTURE_PAT;
    end else if (state_i == TS_CAP_IR) begin
      sh_q <= CAPTURE_PAT;
    end else if (state_i == TS_SH_IR) begin
      sh_q <= {tdi_i, sh_q[IR_W-1:1]};
    end
  end

  // parallel stage moves on the falling edge only
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                     instr_q <= OP_IDCODE;
    else if (state_i == TS_RESET)    instr_q <= OP_IDCODE;
    else if (state_i == TS_UPD_IR)   instr_q <= sh_q;
  end

  assign ir_tdo_o   = sh_q[0];
  assign ir_shift_o = sh_q;
  assign instr_o    = instr_q;

endmodule

// File: rtl/jtag_cmd.sv
module jtag_cmd
  import jtag_cfg_pkg::*;
(
  input  logic             tck_i,
  input  logic             rst_ni,
  input  tap_state_e       state_i,
  input  logic [IR_W-1:0]  ir_new_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             flash_page_o,
  output logic             user_flash_o
);

  logic [CMD_W-1:0] cmd_q;
  logic             page_q, user_q;

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      page_q <= 1'b0;
      user_q <= 1'b0;
    end else begin
      cmd_q <= '0;
      if (state_i == TS_UPD_IR) begin
        case (ir_new_i)
          OP_REBOOT: cmd_q[CMD_REBOOT] <= 1'b1;
          OP_SAVE:   cmd_q[CMD_SAVE]   <= 1'b1;
          OP_PAGE_ON: begin
            cmd_q[CMD_PAGE_ON] <= 1'b1;
            page_q             <= 1'b1;
          end
          OP_PAGE_OFF: begin
            cmd_q[CMD_PAGE_OFF] <= 1'b1;
            page_q              <= 1'b0;
            user_q              <= 1'b0;
          end
          OP_USER_ON: begin
            // accepted only inside an open flash page
            if (page_q) begin
              cmd_q[CMD_USER_ON] <= 1'b1;
              user_q             <= 1'b1;
            end
          end
          OP_USER_OFF: begin
            cmd_q[CMD_USER_OFF] <= 1'b1;
            user_q              <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign cmd_o        = cmd_q;
  assign flash_page_o = page_q;
  assign user_flash_o = user_q;

endmodule

// File: rtl/jtag_dr.sv
module jtag_dr
  import jtag_cfg_pkg::*;
#(
  parameter int unsigned    ADDR_W     = 8,
  parameter int unsigned    DATA_W     = 8,
  parameter logic [3:0]     ID_VERSION = 4'h1,
  parameter logic [15:0]    ID_PART    = 16'h4A17,
  parameter logic [10:0]    ID_MFR     = 11'h0B5,
  parameter logic [31:0]    USER_CODE  = 32'hC0DE_1234
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  tap_state_e        state_i,
  input  logic              tdi_i,
  input  logic [IR_W-1:0]   instr_i,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              dr_tdo_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              rf_we_o
);

  localparam int unsigned ID_W = 32;
  localparam int unsigned DR_W = (ID_W > ADDR_W) ? ((ID_W > DATA_W) ? ID_W : DATA_W)
                                                 : ((ADDR_W > DATA_W) ? ADDR_W : DATA_W);
  localparam logic [ID_W-1:0] ID_VAL = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

  dr_sel_e           sel;
  logic [DR_W-1:0]   dr_q, dr_nxt, ins_mask, cap_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;

  assign sel = dr_select(instr_i);

  always_comb begin
    unique case (sel)
      DS_ID:   begin ins_mask = DR_W'(1) << (ID_W - 1);   cap_val = DR_W'(ID_VAL);     end
      DS_USER: begin ins_mask = DR_W'(1) << (ID_W - 1);   cap_val = DR_W'(USER_CODE);  end
      DS_ADDR: begin ins_mask = DR_W'(1) << (ADDR_W - 1); cap_val = DR_W'(addr_q);     end
      DS_DATA: begin ins_mask = DR_W'(1) << (DATA_W - 1); cap_val = DR_W'(rf_rdata_i); end
      default: begin ins_mask = DR_W'(1);                 cap_val = '0;                end
    endcase
  end

  // TDI enters at the top bit of the selected length
  assign dr_nxt = ((dr_q >> 1) & ~ins_mask) | (ins_mask & {DR_W{tdi_i}});

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                     dr_q <= '0;
    else if (state_i == TS_CAP_DR)   dr_q <= cap_val;
    else if (state_i == TS_SH_DR)    dr_q <= dr_nxt;
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (state_i == TS_UPD_DR) begin
        if (instr_i == OP_LD_ADDR) addr_q <= dr_q[ADDR_W-1:0];
        if (instr_i == OP_WR_DATA) begin
          wdata_q <= dr_q[DATA_W-1:0];
          we_q    <= 1'b1;
        end
      end
    end
  end

  assign dr_tdo_o   = dr_q[0];
  assign rf_addr_o  = addr_q;
  assign rf_wdata_o = wdata_q;
  assign rf_we_o    = we_q;

endmodule

// File: rtl/jtag_cfg_port.sv
module jtag_cfg_port
  import jtag_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'h4A17,
  parameter logic [10:0] ID_MFR     = 11'h0B5,
  parameter logic [31:0] USER_CODE  = 32'hC0DE_1234
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              tdo_oe_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              rf_we_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic [5:0]        cmd_o,
  output logic              flash_page_o,
  output logic              user_flash_o
);

  tap_state_e      tap_state;
  logic            ir_tdo, dr_tdo;
  logic [IR_W-1:0] ir_shift, instr;
  logic            tdo_q, oe_q;

  jtag_tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (tap_state)
  );

  jtag_ir u_ir (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .state_i    (tap_state),
    .tdi_i      (tdi_i),
    .ir_tdo_o   (ir_tdo),
    .ir_shift_o (ir_shift),
    .instr_o    (instr)
  );

  jtag_cmd u_cmd (
    .tck_i        (tck_i),
    .rst_ni       (rst_ni),
    .state_i      (tap_state),
    .ir_new_i     (ir_shift),
    .cmd_o        (cmd_o),
    .flash_page_o (flash_page_o),
    .user_flash_o (user_flash_o)
  );

  jtag_dr #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ID_VERSION (ID_VERSION),
    .ID_PART    (ID_PART),
    .ID_MFR     (ID_MFR),
    .USER_CODE  (USER_CODE)
  ) u_dr (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .state_i    (tap_state),
    .tdi_i      (tdi_i),
    .instr_i    (instr),
    .rf_rdata_i (rf_rdata_i),
    .dr_tdo_o   (dr_tdo),
    .rf_addr_o  (rf_addr_o),
    .rf_wdata_o (rf_wdata_o),
    .rf_we_o    (rf_we_o)
  );

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= (tap_state == TS_SH_IR) || (tap_state == TS_SH_DR);
      if (tap_state == TS_SH_IR)      tdo_q <= ir_tdo;
      else if (tap_state == TS_SH_DR) tdo_q <= dr_tdo;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = oe_q;

endmodule

// File: rtl/jtag_cfg_port_chk.sv
module jtag_cfg_port_chk
  import jtag_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              tck_i,
  input logic              rst_ni,
  input tap_state_e        state_i,
  input logic              tdo_oe_i,
  input logic              rf_we_i,
  input logic [ADDR_W-1:0] rf_addr_i,
  input logic [5:0]        cmd_i,
  input logic              flash_page_i,
  input logic              user_flash_i
);

  p_reset_quiet_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TS_RESET) |-> !tdo_oe_i);

  p_oe_only_shift_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_i |-> (state_i == TS_SH_IR || state_i == TS_SH_DR));

  p_addr_hold_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != TS_UPD_DR) |-> $stable(rf_addr_i));

  p_we_single_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    rf_we_i |=> !rf_we_i);

  p_cmd_onehot_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0(cmd_i));

  p_cmd_single_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cmd_i != '0) |=> (cmd_i == '0));

  p_user_in_page_r12: assert property (@(posedge tck_i) disable iff (!rst_ni)
    user_flash_i |-> flash_page_i);

endmodule

bind jtag_cfg_port jtag_cfg_port_chk #(.ADDR_W(ADDR_W)) i_chk (
  .tck_i        (tck_i),
  .rst_ni       (rst_ni),
  .state_i      (tap_state),
  .tdo_oe_i     (tdo_oe_o),
  .rf_we_i      (rf_we_o),
  .rf_addr_i    (rf_addr_o),
  .cmd_i        (cmd_o),
  .flash_page_i (flash_page_o),
  .user_flash_i (user_flash_o)
);

// File: tb/test_jtag_cfg_port.sv
module test_jtag_cfg_port;

  localparam logic [31:0] EXP_ID   = {4'h1, 16'h4A17, 11'h0B5, 1'b1};
  localparam logic [31:0] EXP_USER = 32'hC0DE_1234;

  // bench-side state numbering
  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHD = 4, S_E1D = 5,
                 S_PD = 6, S_E2D = 7, S_UD = 8, S_SIR = 9, S_CIR = 10, S_SHI = 11,
                 S_E1I = 12, S_PI = 13, S_E2I = 14, S_UI = 15;

  logic       tck = 1'b0, rst_ni = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic       tdo, tdo_oe, rf_we, flash_page, user_flash;
  logic [7:0] rf_addr, rf_wdata, rf_rdata;
  logic [5:0] cmd;

  int n_vec = 0, n_err = 0;
  bit done = 0;

  always #2 tck = ~tck;

  assign rf_rdata = rf_addr ^ 8'h5A;

  jtag_cfg_port #(
    .ADDR_W(8), .DATA_W(8), .ID_VERSION(4'h1), .ID_PART(16'h4A17),
    .ID_MFR(11'h0B5), .USER_CODE(32'hC0DE_1234)
  ) i_jtag_cfg_port (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_oe_o(tdo_oe), .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata),
    .rf_we_o(rf_we), .rf_rdata_i(rf_rdata), .cmd_o(cmd),
    .flash_page_o(flash_page), .user_flash_o(user_flash)
  );

  // ---------------- reference model ----------------
  int         m_st = S_TLR;
  bit         m_irq[$];
  bit         m_dq[$];
  logic [4:0] m_ir = 5'h00;
  logic [7:0] m_addr = 8'h00, m_wdata = 8'h00;
  logic       m_we = 0, m_oe = 0, m_tdo = 0, m_page = 0, m_user = 0;
  logic [5:0] m_cmd = '0;

  function automatic int nxt(int s, bit t);
    case (s)
      S_TLR: return t ? S_TLR : S_RTI;
      S_RTI: return t ? S_SDR : S_RTI;
      S_SDR: return t ? S_SIR : S_CDR;
      S_CDR: return t ? S_E1D : S_SHD;
      S_SHD: return t ? S_E1D : S_SHD;
      S_E1D: return t ? S_UD  : S_PD;
      S_PD:  return t ? S_E2D : S_PD;
      S_E2D: return t ? S_UD  : S_SHD;
      S_UD:  return t ? S_SDR : S_RTI;
      S_SIR: return t ? S_TLR : S_CIR;
      S_CIR: return t ? S_E1I : S_SHI;
      S_SHI: return t ? S_E1I : S_SHI;
      S_E1I: return t ? S_UI  : S_PI;
      S_PI:  return t ? S_E2I : S_PI;
      S_E2I: return t ? S_UI  : S_SHI;
      default: return t ? S_SDR : S_RTI;
    endcase
  endfunction

  function automatic logic [31:0] q2v(bit q[$]);
    logic [31:0] v = '0;
    foreach (q[i]) v[i] = q[i];
    return v;
  endfunction

  function automatic string dr_tag(logic [4:0] ir);
    case (ir)
      5'h00: return "R5";
      5'h03: return "R6";
      5'h04: return "R8";
      5'h05: return "R9";
      5'h06: return "R10";
      default: return "R7";
    endcase
  endfunction

  task automatic model_reset();
    m_st = S_TLR; m_irq.delete(); m_dq.delete();
    m_ir = 5'h00; m_addr = 0; m_wdata = 0; m_we = 0; m_oe = 0; m_tdo = 0;
    m_page = 0; m_user = 0; m_cmd = '0;
  endtask

  task automatic model_pos(bit t, bit d);
    int len;
    logic [31:0] v;
    if (m_st == S_CIR) m_irq = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    else if (m_st == S_SHI) begin void'(m_irq.pop_front()); m_irq.push_back(d); end
    else if (m_st == S_CDR) begin
      case (m_ir)
        5'h00:        begin len = 32; v = EXP_ID; end
        5'h03:        begin len = 32; v = EXP_USER; end
        5'h04:        begin len = 8;  v = 32'(m_addr); end
        5'h05, 5'h06: begin len = 8;  v = 32'(m_addr ^ 8'h5A); end
        default:      begin len = 1;  v = 0; end
      endcase
      m_dq.delete();
      for (int i = 0; i < len; i++) m_dq.push_back(v[i]);
    end else if (m_st == S_SHD) begin void'(m_dq.pop_front()); m_dq.push_back(d); end
    m_st = nxt(m_st, t);
  endtask

  task automatic model_neg();
    logic [4:0] nw;
    m_cmd = '0; m_we = 0;
    m_oe = (m_st == S_SHI) || (m_st == S_SHD);
    if (m_st == S_SHI) m_tdo = m_irq[0];
    if (m_st == S_SHD) m_tdo = m_dq[0];
    if (m_st == S_TLR) m_ir = 5'h00;
    if (m_st == S_UI) begin
      nw = 5'(q2v(m_irq));
      m_ir = nw;
      case (nw)
        5'h07: m_cmd[0] = 1;
        5'h08: m_cmd[1] = 1;
        5'h09: begin m_cmd[2] = 1; m_page = 1; end
        5'h0A: begin m_cmd[3] = 1; m_page = 0; m_user = 0; end
        5'h0B: if (m_page) begin m_cmd[4] = 1; m_user = 1; end
        5'h0C: begin m_cmd[5] = 1; m_user = 0; end
        default: ;
      endcase
    end
    if (m_st == S_UD) begin
      if (m_ir == 5'h04) m_addr = 8'(q2v(m_dq));
      if (m_ir == 5'h06) begin m_wdata = 8'(q2v(m_dq)); m_we = 1; end
    end
  endtask

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 tdo_oe", 32'(tdo_oe), 32'(m_oe));
    if (m_oe) chk(m_st == S_SHI ? "R3 tdo" : dr_tag(m_ir), 32'(tdo), 32'(m_tdo));
    chk("R8 rf_addr", 32'(rf_addr), 32'(m_addr));
    chk("R10 rf_we", 32'(rf_we), 32'(m_we));
    chk("R10 rf_wdata", 32'(rf_wdata), 32'(m_wdata));
    chk("R11 cmd", 32'(cmd), 32'(m_cmd));
    chk("R12 flags", {30'd0, flash_page, user_flash}, {30'd0, m_page, m_user});
  endtask

  task automatic tick(bit t, bit d);
    tms = t; tdi = d;
    @(posedge tck);
    model_pos(t, d);
    @(negedge tck);
    model_neg();
    #1 compare_all();
  endtask

  task automatic scan_ir(logic [4:0] code, bit pause, output logic [4:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) begin
      cap[i] = tdo;
      tick(i == 4, code[i]);
    end
    if (pause) begin tick(0, 0); tick(0, 0); tick(1, 0); end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(int len, logic [31:0] din, bit pause, output logic [31:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo;
      tick(i == len - 1, din[i]);
    end
    if (pause) begin tick(0, 0); tick(0, 0); tick(1, 0); end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      n_err++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [4:0]  ic;
    logic [31:0] d;
    model_reset();
    repeat (3) @(negedge tck);
    #1;
    chk("R1 reset oe", 32'(tdo_oe), 0);
    chk("R1 reset cmd", 32'(cmd), 0);
    chk("R1 reset flags", {30'd0, flash_page, user_flash}, 0);
    chk("R1 reset addr", 32'(rf_addr), 0);
    rst_ni = 1'b1;
    tick(0, 0);

    // IDCODE after reset, capture pattern of IR
    scan_dr(32, 32'h0, 0, d);
    chk("R1 idcode default", d, EXP_ID);
    chk("R5 id layout", 32'(d[0]), 1);
    scan_ir(5'h03, 1, ic);
    chk("R3 ir capture", 32'(ic), 32'h01);
    scan_dr(32, 32'h0, 1, d);
    chk("R4 pause path instr", d, EXP_USER);
    chk("R6 usercode", d, EXP_USER);

    // bypass, unassigned, command codes act as one bit
    scan_ir(5'h1F, 0, ic);
    scan_dr(9, 32'h1A5, 0, d);
    chk("R7 bypass", d & 32'h1FF, {22'd0, 9'h1A5, 1'b0} & 32'h1FF);
    scan_ir(5'h15, 0, ic);
    scan_dr(9, 32'h0F3, 0, d);
    chk("R7 unassigned", d & 32'h1FF, {22'd0, 9'h0F3, 1'b0} & 32'h1FF);

    // address and data access
    scan_ir(5'h04, 0, ic);
    scan_dr(8, 32'h3C, 0, d);
    chk("R8 addr update", 32'(rf_addr), 32'h3C);
    scan_dr(8, 32'h3C, 1, d);
    chk("R8 addr capture", d & 32'hFF, 32'h3C);
    scan_ir(5'h05, 0, ic);
    scan_dr(8, 32'hFF, 0, d);
    chk("R9 read capture", d & 32'hFF, 32'h3C ^ 32'h5A);
    chk("R10 no write on read", 32'(rf_wdata), 0);
    scan_ir(5'h06, 0, ic);
    scan_dr(8, 32'h81, 0, d);
    chk("R10 wdata", 32'(rf_wdata), 32'h81);

    // commands and flags
    scan_ir(5'h0B, 0, ic);
    chk("R12 user refused", 32'(user_flash), 0);
    scan_ir(5'h09, 0, ic);
    chk("R12 page on", 32'(flash_page), 1);
    scan_ir(5'h0B, 0, ic);
    chk("R12 user on", 32'(user_flash), 1);
    scan_ir(5'h0C, 0, ic);
    chk("R12 user off", 32'(user_flash), 0);
    scan_ir(5'h0B, 0, ic);
    scan_ir(5'h0A, 0, ic);
    chk("R12 page off clears", {30'd0, flash_page, user_flash}, 0);
    scan_ir(5'h07, 0, ic);
    scan_ir(5'h07, 1, ic);
    scan_ir(5'h08, 0, ic);
    scan_dr(4, 32'h6, 0, d);
    chk("R11 command acts as bypass", d & 32'hF, 32'h6 << 1 & 32'hF);

    // random walk over the graph
    for (int k = 0; k < 4000; k++) tick(1'($urandom), 1'($urandom));

    // synchronous return to reset
    repeat (5) tick(1, 0);
    chk("R1 tms reset oe", 32'(tdo_oe), 0);
    tick(0, 0);
    scan_dr(32, 32'h0, 0, d);
    chk("R1 idcode after tms reset", d, EXP_ID);

    done = 1;
    summary();
    $finish;
  end

endmodule